// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the memory routing state of one bridge port and classifies memory requests with it. It has two windows. The first covers only the low 4 GB. The second is prefetchable and takes a 64-bit address through two extension dwords. Both windows are 1 MB granular and both bounds are inclusive. Software programs the windows through a small dword-addressed configuration port with byte enables. The configuration read path is combinational.

The block has two classification ports, and each carries a request valid and a 64-bit address. For a host-side (downstream) request, the block forwards it to the device when the address falls in either window and the memory enable input is high. For a device-side (upstream) request, the block forwards it to the host when the address misses both windows and the bus-master enable input is high. The command register itself is outside this block, so both enables arrive as plain inputs. Each decision is registered and comes out with a valid strobe.

Top module: `bmw_decode`

## Requirements
- R1: After reset, dwords 8, 10 and 11 read 0x00000000. Dword 9 reads 0x00010001 when 64-bit support is on and 0x00000000 when it is off. No output strobe is active.
- R2: Dword 8 holds the low-memory base in bits 15:4 and the low-memory limit in bits 31:20. Bits 3:0 and 19:16 read zero and cannot be written, so writing all ones reads back 0xFFF0FFF0.
- R3: Dword 9 holds the prefetchable base in bits 15:4 and the prefetchable limit in bits 31:20. Bits 3:0 and 19:16 are read-only indicators equal to 1h when 64-bit support is on, so writing all ones reads back 0xFFF1FFF1.
- R4: When 64-bit support is on, dwords 10 and 11 hold the upper 32 address bits of the prefetchable base and limit, and every bit of them is writable. When it is off, they read zero and compare as zero.
- R5: A write changes only the bytes whose enable bit is set (cfg_be[n] covers data bits 8n+7:8n).
- R6: The low window hits when address bits 63:32 are zero and base ≤ address[31:20] ≤ limit, with both bounds inclusive. A base equal to the limit selects exactly one 1 MB block.
- R7: The prefetchable window hits when {upper base, base} ≤ {address[63:32], address[31:20]} ≤ {upper limit, limit}, compared as one 44-bit value.
- R8: A window whose combined base is greater than its combined limit matches no address.
- R9: A downstream request is forwarded (dn_fwd=1) only when it hits at least one window and mem_en was high in the request cycle.
- R10: An upstream request is forwarded (up_fwd=1) only when it misses both windows and master_en was high in the request cycle.
- R11: Each result strobe is high exactly one cycle after its request valid. Without a strobe, the forward flag is zero.
- R12: Writes to dword addresses other than 8 to 11 change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| mem_en | input | 1 | Memory space enable, gates downstream forwarding |
| master_en | input | 1 | Bus-master enable, gates upstream forwarding |
| dn_vld | input | 1 | Downstream request valid |
| dn_addr | input | 64 | Downstream request address |
| dn_out_vld | output | 1 | Downstream result strobe |
| dn_fwd | output | 1 | Forward downstream request to device |
| up_vld | input | 1 | Upstream request valid |
| up_addr | input | 64 | Upstream request address |
| up_out_vld | output | 1 | Upstream result strobe |
| up_fwd | output | 1 | Forward upstream request to host |

## Verification
A configuration read answers in the same cycle, so the bench samples cfg_rdata one time step after it sets the address. A configuration write takes effect at the next rising edge, so the bench starts a request or read only after that edge. A forwarding result is due at the first rising edge after its request is presented. The bench drives each request on a falling edge and checks the strobe and flag just after the next rising edge. It then drops the request and checks one edge later that the strobes have returned to zero.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int DW       = 32;
  localparam int BE_W     = DW / 8;
  localparam int ADDR_W   = 64;
  localparam int GRAN     = 20;
  localparam int FLD_W    = DW - GRAN;
  localparam int HI_W     = ADDR_W - DW;
  localparam int KEY_W    = ADDR_W - GRAN;
  localparam int BASE_LSB = 16 - FLD_W;
  localparam int LIM_LSB  = GRAN;
  localparam int NWIN     = 2;
  localparam int WIN_LOW  = 0;
  localparam int WIN_PF   = 1;

  typedef logic [FLD_W-1:0] fld_t;
  typedef logic [HI_W-1:0]  hi_t;
  typedef logic [KEY_W-1:0] key_t;

  typedef struct packed {
    key_t lo;
    key_t hi;
  } win_t;

  // Inclusive bounds; an inverted window is empty.
  function automatic logic in_window(input win_t w, input key_t k);
    return (w.lo <= w.hi) && (k >= w.lo) && (k <= w.hi);
  endfunction

  // 1 MB block number of a full address.
  function automatic key_t addr_key(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAN];
  endfunction

  // Per-byte merge of write data into the current image.
  function automatic logic [DW-1:0] merge_be(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd,
                                             input logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < BE_W; b++) begin
      r[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : cur[b*8 +: 8];
    end
    return r;
  endfunction

  // Extracts the base or limit field from a dword image.
  function automatic fld_t base_of(input logic [DW-1:0] img);
    return img[BASE_LSB +: FLD_W];
  endfunction

  function automatic fld_t lim_of(input logic [DW-1:0] img);
    return img[LIM_LSB +: FLD_W];
  endfunction
endpackage

// File: rtl/bmw_cfg_regs.sv
module bmw_cfg_regs
  import bmw_pkg::*;
#(
  parameter int CFG_AW   = 6,
  parameter int UPPER_EN = 1,
  parameter int LOW_DW   = 8,
  parameter int PF_DW    = 9,
  parameter int UB_DW    = 10,
  parameter int UL_DW    = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  input  logic [BE_W-1:0]       cfg_be,
  output logic [DW-1:0]         cfg_rdata,
  output win_t [NWIN-1:0]       wins
);
  localparam logic [BASE_LSB-1:0] IND = (UPPER_EN != 0) ? BASE_LSB'(1) : '0;
  localparam logic [CFG_AW-1:0] A_LOW = CFG_AW'(LOW_DW);
  localparam logic [CFG_AW-1:0] A_PF  = CFG_AW'(PF_DW);
  localparam logic [CFG_AW-1:0] A_UB  = CFG_AW'(UB_DW);
  localparam logic [CFG_AW-1:0] A_UL  = CFG_AW'(UL_DW);

  fld_t low_base, low_lim, pf_base, pf_lim;
  hi_t  ub_q, ul_q;

  logic [DW-1:0] low_img, pf_img, ub_img, ul_img;
  logic [DW-1:0] low_new, pf_new, ub_new, ul_new;
  logic          wr_low, wr_pf, wr_ub, wr_ul;

  // Read images with read-only bits filled in.
  assign low_img = {low_lim, {(GRAN-16){1'b0}}, low_base, {BASE_LSB{1'b0}}};
  assign pf_img  = {pf_lim, IND, pf_base, IND};
  assign ub_img  = DW'(ub_q);
  assign ul_img  = DW'(ul_q);

  assign wr_low = cfg_wr && (cfg_addr == A_LOW);
  assign wr_pf  = cfg_wr && (cfg_addr == A_PF);
  assign wr_ub  = cfg_wr && (cfg_addr == A_UB);
  assign wr_ul  = cfg_wr && (cfg_addr == A_UL);

  assign low_new = merge_be(low_img, cfg_wdata, cfg_be);
  assign pf_new  = merge_be(pf_img,  cfg_wdata, cfg_be);
  assign ub_new  = merge_be(ub_img,  cfg_wdata, cfg_be);
  assign ul_new  = merge_be(ul_img,  cfg_wdata, cfg_be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_base <= '0;
      low_lim  <= '0;
      pf_base  <= '0;
      pf_lim   <= '0;
    end else begin
      if (wr_low) begin
        low_base <= base_of(low_new);
        low_lim  <= lim_of(low_new);
      end
      if (wr_pf) begin
        pf_base <= base_of(pf_new);
        pf_lim  <= lim_of(pf_new);
      end
    end
  end

  generate
    if (UPPER_EN != 0) begin : g_upper
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ub_q <= '0;
          ul_q <= '0;
        end else begin
          if (wr_ub) ub_q <= ub_new[HI_W-1:0];
          if (wr_ul) ul_q <= ul_new[HI_W-1:0];
        end
      end
    end else begin : g_no_upper
      assign ub_q = '0;
      assign ul_q = '0;
    end
  endgenerate

  always_comb begin
    case (cfg_addr)
      A_LOW:   cfg_rdata = low_img;
      A_PF:    cfg_rdata = pf_img;
      A_UB:    cfg_rdata = ub_img;
      A_UL:    cfg_rdata = ul_img;
      default: cfg_rdata = '0;
    endcase
  end

  // Low window lives entirely below 4 GB: upper key bits are zero.
  assign wins[WIN_LOW].lo = {{HI_W{1'b0}}, low_base};
  assign wins[WIN_LOW].hi = {{HI_W{1'b0}}, low_lim};
  assign wins[WIN_PF].lo  = {ub_q, pf_base};
  assign wins[WIN_PF].hi  = {ul_q, pf_lim};
endmodule

// File: rtl/bmw_win_bank.sv
module bmw_win_bank
  import bmw_pkg::*;
(
  input  win_t [NWIN-1:0]    wins,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NWIN-1:0]    hit,
  output logic               hit_any
);
  key_t key;
  assign key = addr_key(addr);

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign hit[w] = in_window(wins[w], key);
    end
  endgenerate

  assign hit_any = |hit;
endmodule

// File: rtl/bmw_route.sv
module bmw_route (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_en,
  input  logic master_en,
  input  logic dn_vld,
  input  logic dn_hit_any,
  input  logic up_vld,
  input  logic up_hit_any,
  output logic dn_out_vld,
  output logic dn_fwd,
  output logic up_out_vld,
  output logic up_fwd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_out_vld <= 1'b0;
      dn_fwd     <= 1'b0;
      up_out_vld <= 1'b0;
      up_fwd     <= 1'b0;
    end else begin
      dn_out_vld <= dn_vld;
      dn_fwd     <= dn_vld && dn_hit_any && mem_en;
      up_out_vld <= up_vld;
      up_fwd     <= up_vld && !up_hit_any && master_en;
    end
  end
endmodule

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
#(
  parameter int CFG_AW   = 6,
  parameter int UPPER_EN = 1,
  parameter int LOW_DW   = 8,
  parameter int PF_DW    = 9,
  parameter int UB_DW    = 10,
  parameter int UL_DW    = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic [3:0]         cfg_be,
  output logic [31:0]        cfg_rdata,
  input  logic               mem_en,
  input  logic               master_en,
  input  logic               dn_vld,
  input  logic [63:0]        dn_addr,
  output logic               dn_out_vld,
  output logic               dn_fwd,
  input  logic               up_vld,
  input  logic [63:0]        up_addr,
  output logic               up_out_vld,
  output logic               up_fwd
);
  win_t [NWIN-1:0] wins;
  logic [NWIN-1:0] dn_hit, up_hit;
  logic            dn_hit_any, up_hit_any;

  bmw_cfg_regs #(
    .CFG_AW(CFG_AW), .UPPER_EN(UPPER_EN), .LOW_DW(LOW_DW),
    .PF_DW(PF_DW), .UB_DW(UB_DW), .UL_DW(UL_DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .wins(wins)
  );

  bmw_win_bank u_dn_bank (
    .wins(wins), .addr(dn_addr), .hit(dn_hit), .hit_any(dn_hit_any)
  );

  bmw_win_bank u_up_bank (
    .wins(wins), .addr(up_addr), .hit(up_hit), .hit_any(up_hit_any)
  );

  bmw_route u_route (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .master_en(master_en),
    .dn_vld(dn_vld), .dn_hit_any(dn_hit_any),
    .up_vld(up_vld), .up_hit_any(up_hit_any),
    .dn_out_vld(dn_out_vld), .dn_fwd(dn_fwd),
    .up_out_vld(up_out_vld), .up_fwd(up_fwd)
  );
endmodule

// File: rtl/bmw_checker.sv
module bmw_checker
  import bmw_pkg::*;
#(
  parameter int CFG_AW   = 6,
  parameter int UPPER_EN = 1,
  parameter int LOW_DW   = 8,
  parameter int PF_DW    = 9,
  parameter int UB_DW    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              mem_en,
  input logic              master_en,
  input logic              dn_vld,
  input logic              up_vld,
  input logic              dn_out_vld,
  input logic              dn_fwd,
  input logic              up_out_vld,
  input logic              up_fwd,
  input win_t [NWIN-1:0]   wins,
  input logic [NWIN-1:0]   dn_hit,
  input logic              dn_hit_any,
  input logic              up_hit_any
);
  localparam logic [3:0] IND = (UPPER_EN != 0) ? 4'h1 : 4'h0;

  AST_LOW_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CFG_AW'(LOW_DW)) |-> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[19:16] == 4'h0)); // R2
  AST_PF_INDICATOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CFG_AW'(PF_DW)) |-> (cfg_rdata[3:0] == IND && cfg_rdata[19:16] == IND)); // R3
  AST_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (UPPER_EN == 0 && cfg_addr == CFG_AW'(UB_DW)) |-> (cfg_rdata == 32'h0)); // R4
  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wins[WIN_LOW].lo > wins[WIN_LOW].hi) |-> !dn_hit[WIN_LOW]); // R8
  AST_EMPTY_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (wins[WIN_PF].lo > wins[WIN_PF].hi) |-> !dn_hit[WIN_PF]); // R8
  AST_DN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fwd |-> ($past(mem_en) && $past(dn_hit_any))); // R9
  AST_UP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    up_fwd |-> ($past(master_en) && !$past(up_hit_any))); // R10
  AST_DN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_vld |=> dn_out_vld); // R11
  AST_DN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_vld |=> (!dn_out_vld && !dn_fwd)); // R11
  AST_UP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    up_vld |=> up_out_vld); // R11
  AST_UP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !up_vld |=> (!up_out_vld && !up_fwd)); // R11
endmodule

bind bmw_decode bmw_checker #(
  .CFG_AW(CFG_AW), .UPPER_EN(UPPER_EN), .LOW_DW(LOW_DW), .PF_DW(PF_DW), .UB_DW(UB_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .mem_en(mem_en), .master_en(master_en), .dn_vld(dn_vld), .up_vld(up_vld),
  .dn_out_vld(dn_out_vld), .dn_fwd(dn_fwd), .up_out_vld(up_out_vld), .up_fwd(up_fwd),
  .wins(wins), .dn_hit(dn_hit), .dn_hit_any(dn_hit_any), .up_hit_any(up_hit_any)
);

// File: tb/sim_bmw_decode.sv
module sim_bmw_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b0, master_en = 1'b0;
  logic        dn_vld = 1'b0, up_vld = 1'b0;
  logic [63:0] dn_addr = '0, up_addr = '0;
  logic        dn_out_vld, dn_fwd, up_out_vld, up_fwd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bmw_decode u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .master_en(master_en),
    .dn_vld(dn_vld), .dn_addr(dn_addr), .dn_out_vld(dn_out_vld), .dn_fwd(dn_fwd),
    .up_vld(up_vld), .up_addr(up_addr), .up_out_vld(up_out_vld), .up_fwd(up_fwd)
  );

  // {addr[63:0], mem_en, master_en, exp dn_fwd, exp up_fwd}
  // Low window 0x100..0x1FF, prefetch window {1,0x800}..{1,0xFFF}.
  localparam int NVEC = 12;
  localparam logic [67:0] VEC [NVEC] = '{
    {64'h0000_0000_1000_0000, 4'b1110},
    {64'h0000_0000_1FFF_FFFF, 4'b1110},
    {64'h0000_0000_0FFF_FFFF, 4'b1101},
    {64'h0000_0000_2000_0000, 4'b1101},
    {64'h0000_0001_1000_0000, 4'b1101},
    {64'h0000_0001_8000_0000, 4'b1110},
    {64'h0000_0001_FFFF_FFFF, 4'b1110},
    {64'h0000_0002_0000_0000, 4'b1101},
    {64'h0000_0000_1000_0000, 4'b0100},
    {64'h0000_0000_2000_0000, 4'b1000},
    {64'h0000_0001_7FF0_0000, 4'b1101},
    {64'h0000_0000_1800_0000, 4'b0000}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_expect(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic request(input string req, input logic [63:0] a, input logic me,
                         input logic ma, input logic exp_dn, input logic exp_up);
    @(negedge clk);
    dn_vld = 1'b1; up_vld = 1'b1; dn_addr = a; up_addr = a;
    mem_en = me; master_en = ma;
    @(posedge clk);
    #1;
    check({req, " R11 strobe"}, {62'b0, dn_out_vld, up_out_vld}, 64'h3);
    check({req, " dn_fwd"}, dn_fwd, exp_dn);
    check({req, " up_fwd"}, up_fwd, exp_up);
    @(negedge clk);
    dn_vld = 1'b0; up_vld = 1'b0;
    @(posedge clk);
    #1;
    check("R11 idle", {60'b0, dn_out_vld, dn_fwd, up_out_vld, up_fwd}, 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cfg_expect("R1 low", 6'd8, 32'h0000_0000);
    cfg_expect("R1 pf", 6'd9, 32'h0001_0001);
    cfg_expect("R1 ub", 6'd10, 32'h0);
    cfg_expect("R1 ul", 6'd11, 32'h0);
    check("R1 strobes", {62'b0, dn_out_vld, up_out_vld}, 64'h0);

    // Programme windows (R4 upper dwords, R6/R7 windows)
    cfg_write(6'd8, 32'h1FF0_1000, 4'hF);
    cfg_write(6'd9, 32'hFFF0_8000, 4'hF);
    cfg_write(6'd10, 32'h0000_0001, 4'hF);
    cfg_write(6'd11, 32'h0000_0001, 4'hF);

    // Table: R6 low window, R7 prefetch window, R9/R10 gating
    for (int i = 0; i < NVEC; i++) begin
      request($sformatf("R6/R7/R9/R10 vec%0d", i), VEC[i][67:4],
              VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6 single-block window: base == limit
    cfg_write(6'd8, 32'h3000_3000, 4'hF);
    request("R6 one-block hit", 64'h0000_0000_300F_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    request("R6 one-block miss", 64'h0000_0000_3010_0000, 1'b1, 1'b1, 1'b0, 1'b1);

    // R8 inverted windows match nothing
    cfg_write(6'd8, 32'h0FF0_2000, 4'hF);
    request("R8 low inverted", 64'h0000_0000_0FF0_0000, 1'b1, 1'b1, 1'b0, 1'b1);
    request("R8 low inverted b", 64'h0000_0000_2000_0000, 1'b1, 1'b1, 1'b0, 1'b1);
    cfg_write(6'd10, 32'h0000_0002, 4'hF);
    request("R8 pf inverted", 64'h0000_0001_9000_0000, 1'b1, 1'b1, 1'b0, 1'b1);
    request("R8 pf inverted b", 64'h0000_0002_9000_0000, 1'b1, 1'b1, 1'b0, 1'b1);

    // R2 read-only zero bits
    cfg_write(6'd8, 32'hFFFF_FFFF, 4'hF);
    cfg_expect("R2 all ones", 6'd8, 32'hFFF0_FFF0);
    // R5 byte enables
    cfg_write(6'd8, 32'h1FF0_1000, 4'hF);
    cfg_write(6'd8, 32'hAAAA_AAAA, 4'b0010);
    cfg_expect("R5 byte1 only", 6'd8, 32'h1FF0_AA00);
    // R3 indicators read-only
    cfg_write(6'd9, 32'hFFFF_FFFF, 4'hF);
    cfg_expect("R3 all ones", 6'd9, 32'hFFF1_FFF1);
    cfg_write(6'd9, 32'h0000_0000, 4'hF);
    cfg_expect("R3 zeros", 6'd9, 32'h0001_0001);
    // R4 upper dwords fully writable
    cfg_write(6'd10, 32'h1234_5678, 4'hF);
    cfg_expect("R4 ub", 6'd10, 32'h1234_5678);
    cfg_write(6'd11, 32'hFFFF_FFAB, 4'b0001);
    cfg_expect("R4 ul partial", 6'd11, 32'h0000_00AB);
    // R12 unmapped address
    cfg_write(6'd3, 32'hFFFF_FFFF, 4'hF);
    cfg_expect("R12 unmapped read", 6'd3, 32'h0);
    cfg_expect("R12 low untouched", 6'd8, 32'h1FF0_AA00);
    cfg_expect("R12 pf untouched", 6'd9, 32'h0001_0001);

    finish_run();
  end
endmodule